// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Bank

This block is a general-purpose I/O controller with a width set by a parameter. It sits on a plain synchronous register bus made of a word address, a write strobe, a read strobe and one data word in each direction. One latch holds the output level of every line. Software can load that latch whole through the level register. It can also change single lines by writing ones to the raise register or to the lower register. A single direction state decides which lines drive their pads. Software sees that state through two registers that read as complements of each other: the drive register and the sense register. Pad inputs pass through a two-stage synchroniser before software can read them back.

Two parameters set how register bits map onto lines. When mirroring is on, line n uses register bit WIDTH-1-n in every register. When byte swapping is on, the byte lanes of every bus word are reversed. Both mappings apply to writes and to reads, so a value written is read back unchanged.

The registers sit at word offsets 0 (level), 1 (raise), 2 (lower), 3 (drive) and 4 (sense). Offsets 5 and up are unmapped.

Top module: `mmio_gpio_bank`

## Requirements
- R1: While reset is high and on the cycle after it, pad_out and pad_oe are all zero and bus_rdata is zero. Every line therefore starts as an input.
- R2: A write to the level register (offset 0) loads the output latch with the mapped write word. The new value appears on pad_out from the clock edge that samples the write strobe.
- R3: A write to the raise register (offset 1) drives high every line whose mapped bit is 1. Lines whose bit is 0 keep their level.
- R4: A write to the lower register (offset 2) drives low every line whose mapped bit is 1. Lines whose bit is 0 keep their level.
- R5: A read of the raise register returns the output latch, whatever the pad inputs are.
- R6: A read of the level register returns the pad inputs after two synchronising flops. A pad change made before edge k is returned by a read strobe sampled at edge k+2, and not by one sampled at edge k or k+1.
- R7: A write to the drive register (offset 3) sets the direction state: a 1 makes the line an output (pad_oe high) and a 0 makes it an input. Reading offset 3 returns that state.
- R8: A write to the sense register (offset 4) sets the direction state inverted: a 1 makes the line an input. Reading offset 4 always returns the bitwise complement of offset 3.
- R9: With MIRROR_LINES=1, line n uses register bit DATA_W-1-n in every register.
- R10: With SWAP_BYTES=1, bus byte lane b holds register byte DATA_W/8-1-b. For a 16-bit bank with both options on, bus word 0x0001 maps to line 7 and bus word 0x0100 maps to line 15. A width other than 8, 16, 32 or 64, or byte swapping at width 64, stops elaboration.
- R11: bus_rdata is registered. It holds the addressed value one cycle after a read strobe and zero after any cycle with no read strobe. Offsets 5 to 7 read as zero, and writes to them change neither pad_out nor pad_oe.
- R12: When a read and a write hit the same register in one cycle, the read returns the value from before the write. The lower register always reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write word |
| bus_rdata | output | DATA_W | Registered read word |
| pad_in | input | DATA_W | Pad input levels, one per line |
| pad_out | output | DATA_W | Pad output levels |
| pad_oe | output | DATA_W | Pad output enables, 1 means drive |

## Verification
A read strobe and a write strobe can reach the same register in the same cycle. That raises the question of whether the read sees the old latch or direction value or the new one. The bench raises both strobes together on the raise register and on the drive register. The scoreboard expects the value from before the write, and a pin check right after that edge expects the updated pads. A second collision is between a pad change and a level read. The bench changes pad_in in the same cycle as a read and then reads twice more, expecting old, old, new.

// File: rtl/mmio_gpio_pkg.sv
package mmio_gpio_pkg;
  typedef enum logic [2:0] {
    OFS_LEVEL = 3'd0,
    OFS_RAISE = 3'd1,
    OFS_LOWER = 3'd2,
    OFS_DRIVE = 3'd3,
    OFS_SENSE = 3'd4
  } gpio_ofs_e;

  localparam int MAPPED_REGS = 5;
endpackage

// File: rtl/gpio_bitmap.sv
module gpio_bitmap #(
  parameter int DATA_W       = 32,
  parameter bit MIRROR_LINES = 1'b0,
  parameter bit SWAP_BYTES   = 1'b0
) (
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int NBYTES = DATA_W / 8;

  // Byte swap and bit mirror are both involutions and commute, so one
  // instance serves the bus-to-line and line-to-bus directions alike.
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam int BYTE_IX = i / 8;
    localparam int BIT_IX  = i % 8;
    localparam int SW_POS  = SWAP_BYTES ? (NBYTES - 1 - BYTE_IX) * 8 + BIT_IX : i;
    localparam int DST     = MIRROR_LINES ? DATA_W - 1 - SW_POS : SW_POS;
    assign dout[i] = din[DST];
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int DATA_W = 32,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] async_in,
  output logic [DATA_W-1:0] sync_out
);
  logic [DATA_W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= async_in;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_out_ctl.sv
module gpio_out_ctl #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_level,
  input  logic              we_raise,
  input  logic              we_lower,
  input  logic              we_drive,
  input  logic              we_sense,
  input  logic [DATA_W-1:0] lines,
  output logic [DATA_W-1:0] latch_q,
  output logic [DATA_W-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
    end else if (we_level) begin
      latch_q <= lines;
    end else if (we_raise) begin
      latch_q <= latch_q | lines;
    end else if (we_lower) begin
      latch_q <= latch_q & ~lines;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
    end else if (we_drive) begin
      dir_q <= lines;
    end else if (we_sense) begin
      dir_q <= ~lines;
    end
  end

  AST_ONE_WRITE_PORT: assert property (@(posedge clk) disable iff (rst)
    $countones({we_level, we_raise, we_lower, we_drive, we_sense}) <= 1); // R11
endmodule

// File: rtl/mmio_gpio_bank.sv
module mmio_gpio_bank
  import mmio_gpio_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter bit MIRROR_LINES = 1'b0,
  parameter bit SWAP_BYTES   = 1'b0,
  parameter int ADDR_W       = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] pad_in,
  output logic [DATA_W-1:0] pad_out,
  output logic [DATA_W-1:0] pad_oe
);
  localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(OFS_LEVEL);
  localparam logic [ADDR_W-1:0] A_RAISE = ADDR_W'(OFS_RAISE);
  localparam logic [ADDR_W-1:0] A_LOWER = ADDR_W'(OFS_LOWER);
  localparam logic [ADDR_W-1:0] A_DRIVE = ADDR_W'(OFS_DRIVE);
  localparam logic [ADDR_W-1:0] A_SENSE = ADDR_W'(OFS_SENSE);

  // R10: elaboration-time parameter checks
  if (DATA_W != 8 && DATA_W != 16 && DATA_W != 32 && DATA_W != 64) begin : g_bad_width
    $error("mmio_gpio_bank: DATA_W must be 8, 16, 32 or 64");
  end
  if (SWAP_BYTES && DATA_W == 64) begin : g_bad_swap
    $error("mmio_gpio_bank: byte swapping is not supported at 64 bits");
  end
  if (ADDR_W < 3) begin : g_bad_addr
    $error("mmio_gpio_bank: ADDR_W must cover five registers");
  end

  logic [DATA_W-1:0] wr_lines;
  logic [DATA_W-1:0] rd_lines;
  logic [DATA_W-1:0] rd_bus;
  logic [DATA_W-1:0] pad_sync;
  logic [DATA_W-1:0] latch_q;
  logic [DATA_W-1:0] dir_q;
  logic we_level, we_raise, we_lower, we_drive, we_sense;

  gpio_bitmap #(
    .DATA_W(DATA_W), .MIRROR_LINES(MIRROR_LINES), .SWAP_BYTES(SWAP_BYTES)
  ) u_wr_map (
    .din (bus_wdata),
    .dout(wr_lines)
  );

  gpio_bitmap #(
    .DATA_W(DATA_W), .MIRROR_LINES(MIRROR_LINES), .SWAP_BYTES(SWAP_BYTES)
  ) u_rd_map (
    .din (rd_lines),
    .dout(rd_bus)
  );

  gpio_sync #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_in(pad_in),
    .sync_out(pad_sync)
  );

  assign we_level = bus_wr && (bus_addr == A_LEVEL);
  assign we_raise = bus_wr && (bus_addr == A_RAISE);
  assign we_lower = bus_wr && (bus_addr == A_LOWER);
  assign we_drive = bus_wr && (bus_addr == A_DRIVE);
  assign we_sense = bus_wr && (bus_addr == A_SENSE);

  gpio_out_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .we_level(we_level),
    .we_raise(we_raise),
    .we_lower(we_lower),
    .we_drive(we_drive),
    .we_sense(we_sense),
    .lines   (wr_lines),
    .latch_q (latch_q),
    .dir_q   (dir_q)
  );

  assign pad_out = latch_q;
  assign pad_oe  = dir_q;

  always_comb begin
    rd_lines = '0;
    if (bus_addr == A_LEVEL)      rd_lines = pad_sync;
    else if (bus_addr == A_RAISE) rd_lines = latch_q;
    else if (bus_addr == A_DRIVE) rd_lines = dir_q;
    else if (bus_addr == A_SENSE) rd_lines = ~dir_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_bus;
    else             bus_rdata <= '0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (pad_out == '0 && pad_oe == '0 && bus_rdata == '0)); // R1
  AST_LEVEL_LOADS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_LEVEL) |=> pad_out == $past(wr_lines)); // R2
  AST_RAISE_SETS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_RAISE) |=> (pad_out & $past(wr_lines)) == $past(wr_lines)); // R3
  AST_RAISE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_RAISE) |=> ((pad_out ^ $past(pad_out)) & ~$past(wr_lines)) == '0); // R3
  AST_LOWER_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_LOWER) |=> (pad_out & $past(wr_lines)) == '0); // R4
  AST_LOWER_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_LOWER) |=> ((pad_out ^ $past(pad_out)) & ~$past(wr_lines)) == '0); // R4
  AST_DRIVE_LOADS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_DRIVE) |=> pad_oe == $past(wr_lines)); // R7
  AST_SENSE_LOADS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_SENSE) |=> pad_oe == ~$past(wr_lines)); // R8
  AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr > A_SENSE) |=> ($stable(pad_out) && $stable(pad_oe))); // R11
  AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr > A_SENSE) |=> bus_rdata == '0); // R11
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0); // R11
  AST_LOWER_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_LOWER) |=> bus_rdata == '0); // R12
endmodule

// File: tb/mmio_gpio_bank_tb.sv
module mmio_gpio_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WA = 32;
  localparam int WB = 16;

  typedef struct {
    logic [WA-1:0] exp_a;
    logic [WB-1:0] exp_b;
    string         tag;
  } rd_item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [WA-1:0] bus_wdata = '0;
  logic [WA-1:0] rdata_a;
  logic [WB-1:0] rdata_b;
  logic [WA-1:0] pad_in_a = '0;
  logic [WB-1:0] pad_in_b;
  logic [WA-1:0] pad_out_a, pad_oe_a;
  logic [WB-1:0] pad_out_b, pad_oe_b;
  logic          rd_seen = 1'b0;
  rd_item_t      sb_q[$];
  int            n_checks = 0;
  int            n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Mirrored and byte-swapped bank: swap byte lanes, then reverse bit order
  function automatic logic [WB-1:0] map16(input logic [WB-1:0] v);
    logic [WB-1:0] s;
    logic [WB-1:0] r;
    s = {v[7:0], v[15:8]};
    for (int i = 0; i < WB; i++) r[i] = s[WB-1-i];
    return r;
  endfunction

  assign pad_in_b = map16(pad_in_a[WB-1:0]);

  mmio_gpio_bank #(.DATA_W(WA)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .pad_in(pad_in_a),
    .pad_out(pad_out_a), .pad_oe(pad_oe_a)
  );

  mmio_gpio_bank #(.DATA_W(WB), .MIRROR_LINES(1'b1), .SWAP_BYTES(1'b1)) dut_mx_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata[WB-1:0]), .bus_rdata(rdata_b), .pad_in(pad_in_b),
    .pad_out(pad_out_b), .pad_oe(pad_oe_b)
  );

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per completed read strobe
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb_q.size() == 0) begin
        n_checks++; n_errors++;
        $display("FAIL R11 unexpected read data actual=%h expected=none", rdata_a);
      end else begin
        rd_item_t it;
        it = sb_q.pop_front();
        check(64'(rdata_a), 64'(it.exp_a), {it.tag, " bank32"});
        check(64'(rdata_b), 64'(it.exp_b), {it.tag, " bank16mx"});
      end
    end
  end

  // Driver tasks: entered at a falling edge, return at the next one
  task automatic bus_write(input logic [2:0] a, input logic [WA-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, input logic [WA-1:0] ea,
                          input logic [WB-1:0] eb, input string tag);
    rd_item_t it;
    it.exp_a = ea; it.exp_b = eb; it.tag = tag;
    sb_q.push_back(it);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_rdwr(input logic [2:0] a, input logic [WA-1:0] d,
                          input logic [WA-1:0] ea, input logic [WB-1:0] eb, input string tag);
    rd_item_t it;
    it.exp_a = ea; it.exp_b = eb; it.tag = tag;
    sb_q.push_back(it);
    bus_addr = a; bus_wdata = d; bus_rd = 1'b1; bus_wr = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic pins(input logic [WA-1:0] out_a, input logic [WA-1:0] oe_a, input string tag);
    check(64'(pad_out_a), 64'(out_a), {tag, " pad_out bank32"});
    check(64'(pad_oe_a), 64'(oe_a), {tag, " pad_oe bank32"});
    check(64'(pad_out_b), 64'(map16(out_a[WB-1:0])), {tag, " pad_out bank16mx"});
    check(64'(pad_oe_b), 64'(map16(oe_a[WB-1:0])), {tag, " pad_oe bank16mx"});
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++; n_errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    pins('0, '0, "R1 reset");
    check(64'(rdata_a), 64'd0, "R1 reset rdata");

    // R9 R10: literal mirror and swap mapping on the 16-bit bank
    bus_write(3'd0, 32'h0000_0001);
    check(64'(pad_out_b), 64'h0080, "R9 R10 bus bit0 to line7");
    check(64'(pad_out_a), 64'h1, "R2 level write plain bank");
    bus_write(3'd0, 32'h0000_0100);
    check(64'(pad_out_b), 64'h8000, "R9 R10 bus bit8 to line15");

    // R7 R8: direction through both views
    bus_write(3'd3, 32'h0000_FFFF);
    pins(32'h0000_0100, 32'h0000_FFFF, "R7 drive write");
    bus_read(3'd3, 32'h0000_FFFF, 16'hFFFF, "R7 drive read");
    bus_read(3'd4, 32'hFFFF_0000, 16'h0000, "R8 sense read");
    bus_write(3'd4, 32'hFFFF_FF00);
    pins(32'h0000_0100, 32'h0000_00FF, "R8 sense write");
    bus_read(3'd3, 32'h0000_00FF, 16'h00FF, "R8 drive after sense write");

    // R2 R3 R4: three ways into the output latch
    bus_write(3'd0, 32'hA5A5_5A5A);
    pins(32'hA5A5_5A5A, 32'h0000_00FF, "R2 level write");
    bus_write(3'd1, 32'h0000_0101);
    pins(32'hA5A5_5B5B, 32'h0000_00FF, "R3 raise write");
    bus_write(3'd2, 32'hA000_0001);
    pins(32'h05A5_5B5A, 32'h0000_00FF, "R4 lower write");

    // R5 R6 R12: readback sources
    pad_in_a = 32'h1234_5678;
    repeat (3) @(negedge clk);
    bus_read(3'd1, 32'h05A5_5B5A, 16'h5B5A, "R5 raise reads latch");
    bus_read(3'd0, 32'h1234_5678, 16'h5678, "R6 level reads pads");
    bus_read(3'd2, 32'h0, 16'h0, "R12 lower reads zero");

    // R6: synchroniser latency
    pad_in_a = 32'hCAFE_F00D;
    bus_read(3'd0, 32'h1234_5678, 16'h5678, "R6 sync edge k");
    bus_read(3'd0, 32'h1234_5678, 16'h5678, "R6 sync edge k+1");
    bus_read(3'd0, 32'hCAFE_F00D, 16'hF00D, "R6 sync edge k+2");

    // R11: unmapped offsets and idle read data
    bus_write(3'd5, 32'hFFFF_FFFF);
    pins(32'h05A5_5B5A, 32'h0000_00FF, "R11 unmapped write ignored");
    bus_read(3'd6, 32'h0, 16'h0, "R11 unmapped read");
    @(negedge clk);
    check(64'(rdata_a), 64'd0, "R11 idle rdata zero");
    bus_read(3'd7, 32'h0, 16'h0, "R11 unmapped read top");

    // R12: read and write on one register in one cycle
    bus_rdwr(3'd1, 32'h0000_F000, 32'h05A5_5B5A, 16'h5B5A, "R12 raise collision");
    pins(32'h05A5_FB5A, 32'h0000_00FF, "R12 raise after collision");
    bus_rdwr(3'd3, 32'hFFFF_FFFF, 32'h0000_00FF, 16'h00FF, "R12 drive collision");
    pins(32'h05A5_FB5A, 32'hFFFF_FFFF, "R12 drive after collision");
    bus_read(3'd4, 32'h0, 16'h0, "R8 sense after full drive");

    repeat (2) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_checks++; n_errors++;
      $display("FAIL R11 pending reads actual=%0d expected=0", sb_q.size());
    end
    finish_run();
  end
endmodule